// File: doc/BRIEF.md
# Dual-Unit Multicycle Execute Issue Control

This block steers instructions through a five-step in-order flow: fetch, decode, execute, memory and writeback. The execute step has two separate functional units. The fast unit takes a fixed short latency and the slow unit takes a longer one. Neither unit is pipelined and neither has an input queue. Each instruction names the unit it needs with one select bit, and it uses only that unit. The block tracks when each unit is occupied. An instruction whose unit is taken waits in decode, and that wait holds the fetch slot behind it. No instruction is dropped or duplicated.

Instructions enter through a valid/ready stream that carries a sequence tag and the unit select. The fetch slot takes a new instruction on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must keep its tag and select stable. Finished instructions leave through the writeback port as a single-cycle `wb_valid` pulse that carries their tag. This port has no back-pressure, because writeback always retires what reaches it. A short instruction that starts after a long one can retire first, so the order of the tags at writeback reflects the unit latencies and not the program order. The block computes no data, holds no registers and raises no exceptions.

Top module: `dual_exec_issue_ctrl`

## Requirements
- R1: A synchronous active-high `rst` empties every stage and frees both units. In the first cycle after reset, `in_ready` is 1 and `wb_valid` is 0. An instruction that was in flight when reset was asserted never reaches writeback.
- R2: The select bit `in_unit` = 0 routes to the fast unit, which takes E1_LAT cycles. The select bit `in_unit` = 1 routes to the slow unit, which takes E2_LAT cycles. If an instruction meets no stall and its fetch cycle is F, its tag appears on `wb_valid`/`wb_tag` in cycle F + LAT + 3.
- R3: A unit holds one instruction at a time. An instruction enters a unit only when that unit is empty, or when the unit's occupant moves to memory in that same cycle. As a result, a run of fast-unit instructions retires one every E1_LAT cycles.
- R4: An instruction whose unit is occupied stays in decode with its tag unchanged. While decode is held, the fetch slot keeps its instruction and `in_ready` is low. An input is taken only on an edge with `in_valid` and `in_ready` both high.
- R5: Completion order may differ from program order. A fast-unit instruction fetched after a slow-unit one retires first when its finish cycle comes earlier.
- R6: Both units can finish in the same cycle. When they do, the older instruction moves to memory first. The younger one stays in its unit for one more cycle, which keeps that unit occupied, and it retires one cycle later.
- R7: At most one instruction moves from the units to memory per cycle. Every accepted tag appears on writeback exactly once.
- R8: While `in_valid` is 0, `in_tag` and `in_unit` are ignored. Nothing enters fetch and nothing retires from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch-side instruction offered |
| in_ready | output | 1 | Fetch slot can take an instruction this edge |
| in_tag | input | TAG_W | Sequence tag of the offered instruction |
| in_unit | input | 1 | Unit select: 0 = fast unit, 1 = slow unit |
| wb_valid | output | 1 | An instruction retires this cycle |
| wb_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The bench builds the block with its default parameters: a 4-bit tag, a fast-unit latency of 2 and a slow-unit latency of 4. The 2-cycle gap between the two latencies lets a fast-unit instruction issued two cycles after a slow-unit one finish in the same cycle, which exercises the age-ordered handoff. These latencies also make the stall of a second slow-unit instruction long enough to hold the fetch slot for several cycles. An alternating five-instruction mix gives a fully known schedule, which the bench compares cycle by cycle.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  localparam int UNIT_COUNT = 2;

  typedef enum logic {
    SEL_FAST = 1'b0,
    SEL_SLOW = 1'b1
  } unit_sel_e;
endpackage

// File: rtl/dxe_exec_slot.sv
// One non-pipelined execute unit with no input queue. It counts the cycles
// spent on its occupant and then holds the result until the handoff grants it.
module dxe_exec_slot #(
  parameter int LAT   = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             grant,
  output logic             busy,
  output logic             done,
  output logic             free,
  output logic [TAG_W-1:0] tag
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(LAT));
  assign free = !busy || (done && grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      tag  <= '0;
    end else if (issue) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
      tag  <= issue_tag;
    end else if (done && grant) begin
      busy <= 1'b0;
    end else if (busy && !done) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dxe_leave_arbiter.sv
// Chooses which finished unit moves into memory. When both have finished,
// the older occupant goes first.
module dxe_leave_arbiter (
  input  logic [dxe_pkg::UNIT_COUNT-1:0] done,
  input  logic                           slow_older,
  output logic [dxe_pkg::UNIT_COUNT-1:0] grant
);
  always_comb begin
    if (&done) grant = slow_older ? 2'b10 : 2'b01;
    else       grant = done;
  end
endmodule

// File: rtl/dual_exec_issue_ctrl.sv
module dual_exec_issue_ctrl #(
  parameter int TAG_W  = 4,
  parameter int E1_LAT = 2,
  parameter int E2_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_unit,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  import dxe_pkg::*;
  localparam int NU = UNIT_COUNT;

  // fetch and decode slots
  logic             if_v, id_v;
  logic [TAG_W-1:0] if_t, id_t;
  unit_sel_e        if_u, id_u;
  // memory and writeback slots
  logic             mem_v, wb_v;
  logic [TAG_W-1:0] mem_t, wb_t;

  logic [NU-1:0]    busy, done, free, grant, issue;
  logic [TAG_W-1:0] utag [NU];
  logic             slow_older;
  logic             id_issue, if_adv;

  // decode issue: only into the selected unit, only when that unit frees
  always_comb begin
    issue[0] = id_v && (id_u == SEL_FAST) && free[0];
    issue[1] = id_v && (id_u == SEL_SLOW) && free[1];
  end

  assign id_issue = |issue;
  assign if_adv   = !id_v || id_issue;
  assign in_ready = !if_v || if_adv;

  generate
    for (genvar g = 0; g < NU; g++) begin : g_unit
      dxe_exec_slot #(
        .LAT  (g == 0 ? E1_LAT : E2_LAT),
        .TAG_W(TAG_W)
      ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue[g]),
        .issue_tag(id_t),
        .grant    (grant[g]),
        .busy     (busy[g]),
        .done     (done[g]),
        .free     (free[g]),
        .tag      (utag[g])
      );
    end
  endgenerate

  dxe_leave_arbiter u_arb (
    .done      (done),
    .slow_older(slow_older),
    .grant     (grant)
  );

  // age of the two occupants: set when one issues while the other stays put
  always_ff @(posedge clk) begin
    if (rst) begin
      slow_older <= 1'b0;
    end else if (issue[0] && busy[1] && !grant[1]) begin
      slow_older <= 1'b1;
    end else if (issue[1] && busy[0] && !grant[0]) begin
      slow_older <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_v <= 1'b0;
      if_t <= '0;
      if_u <= SEL_FAST;
    end else if (in_ready) begin
      if_v <= in_valid;
      if_t <= in_tag;
      if_u <= unit_sel_e'(in_unit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_v <= 1'b0;
      id_t <= '0;
      id_u <= SEL_FAST;
    end else if (if_adv) begin
      id_v <= if_v;
      id_t <= if_t;
      id_u <= if_u;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_v <= 1'b0;
      mem_t <= '0;
      wb_v  <= 1'b0;
      wb_t  <= '0;
    end else begin
      mem_v <= |grant;
      mem_t <= grant[1] ? utag[1] : utag[0];
      wb_v  <= mem_v;
      wb_t  <= mem_t;
    end
  end

  assign wb_valid = wb_v;
  assign wb_tag   = wb_t;
endmodule

// File: rtl/dxe_checker.sv
module dxe_checker #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             wb_valid,
  input logic             id_v,
  input logic             id_issue,
  input logic [TAG_W-1:0] id_t,
  input logic [1:0]       busy,
  input logic [1:0]       done,
  input logic [1:0]       grant,
  input logic [1:0]       issue
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wb_valid && in_ready));

  assert_fast_entry_free_R3: assert property (@(posedge clk) disable iff (rst)
    issue[0] |-> (!busy[0] || grant[0]));

  assert_slow_entry_free_R3: assert property (@(posedge clk) disable iff (rst)
    issue[1] |-> (!busy[1] || grant[1]));

  assert_decode_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (id_v && !id_issue) |=> (id_v && $stable(id_t)));

  assert_single_leave_R7: assert property (@(posedge clk) disable iff (rst)
    (|done) |-> ($countones(grant) == 1));

  assert_slow_waits_R6: assert property (@(posedge clk) disable iff (rst)
    (grant == 2'b01 && done[1]) |=> done[1]);

  assert_fast_waits_R6: assert property (@(posedge clk) disable iff (rst)
    (grant == 2'b10 && done[0]) |=> done[0]);
endmodule

bind dual_exec_issue_ctrl dxe_checker #(.TAG_W(TAG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_ready(in_ready),
  .wb_valid(wb_valid),
  .id_v    (id_v),
  .id_issue(id_issue),
  .id_t    (id_t),
  .busy    (busy),
  .done    (done),
  .grant   (grant),
  .issue   (issue)
);

// File: tb/sim_dual_exec_issue_ctrl.sv
module sim_dual_exec_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_tag = '0;
  logic       in_unit = 1'b0;
  logic       wb_valid;
  logic [3:0] wb_tag;

  int cyc = 0;
  int n_pass = 0;
  int n_fail = 0;
  int n_log = 0;
  int log_tag [32];
  int log_cyc [32];

  dual_exec_issue_ctrl u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_unit(in_unit), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wb_valid && n_log < 32) begin
      log_tag[n_log] = int'(wb_tag);
      log_cyc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_log = 0;
  endtask

  // offers one instruction; returns the cycle in which it sits in fetch
  task automatic send(input int t, input bit u, output int fcyc);
    in_valid = 1'b1;
    in_tag = 4'(t);
    in_unit = u;
    forever begin
      #1;
      if (in_ready) begin
        fcyc = cyc + 1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_wb(input int idx, input int t, input int rel,
                           input int base, input string req);
    if (idx >= n_log) begin
      chk(1'b0, req, $sformatf("retire #%0d missing", idx), n_log, idx + 1);
    end else begin
      chk(log_tag[idx] == t, req, $sformatf("tag of retire #%0d", idx), log_tag[idx], t);
      chk(log_cyc[idx] - base + 1 == rel, req, $sformatf("cycle of tag %0d", t),
          log_cyc[idx] - base + 1, rel);
    end
  endtask

  // R1: state right after reset, and discard of in-flight work
  task automatic t_reset();
    int f;
    reset_dut();
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
    send(1, 1'b1, f);
    send(2, 1'b0, f);
    send(3, 1'b1, f);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R1", "wb_valid held in reset", int'(wb_valid), 0);
    rst = 1'b0;
    n_log = 0;
    repeat (20) @(negedge clk);
    chk(n_log == 0, "R1", "retires after mid-flight reset", n_log, 0);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after mid-flight reset", int'(in_ready), 1);
  endtask

  // R2 R3 R4 R5 R7: alternating fast/slow mix of five
  task automatic t_mix();
    int f1, f, f4, f5;
    reset_dut();
    send(1, 1'b0, f1);
    send(2, 1'b1, f);
    send(3, 1'b0, f);
    send(4, 1'b1, f4);
    send(5, 1'b0, f5);
    repeat (20) @(negedge clk);
    chk(f4 - f1 + 1 == 4, "R4", "fetch cycle of tag 4", f4 - f1 + 1, 4);
    chk(f5 - f1 + 1 == 5, "R4", "fetch cycle of tag 5", f5 - f1 + 1, 5);
    expect_wb(0, 1, 6, f1, "R2");
    expect_wb(1, 3, 8, f1, "R5");
    expect_wb(2, 2, 9, f1, "R2");
    expect_wb(3, 5, 12, f1, "R4");
    expect_wb(4, 4, 13, f1, "R3");
    chk(n_log == 5, "R7", "retire count of mix", n_log, 5);
  endtask

  // R6: same-cycle finish, older slow first, fast waits and blocks its unit
  task automatic t_collide();
    int fa, fb, fc;
    reset_dut();
    send(6, 1'b1, fa);
    @(negedge clk);
    send(7, 1'b0, fb);
    send(8, 1'b0, fc);
    repeat (20) @(negedge clk);
    chk(fb - fa + 1 == 3, "R6", "fetch cycle of tag 7", fb - fa + 1, 3);
    expect_wb(0, 6, 8, fa, "R6");
    expect_wb(1, 7, 9, fa, "R6");
    expect_wb(2, 8, 11, fa, "R6");
    chk(n_log == 3, "R7", "retire count of collision", n_log, 3);
  endtask

  // R4 R5: back-to-back slow ops hold fetch; a fast op overtakes
  task automatic t_backpressure();
    int fa, f, fd;
    reset_dut();
    send(9, 1'b1, fa);
    send(10, 1'b1, f);
    send(11, 1'b1, f);
    send(12, 1'b0, fd);
    repeat (24) @(negedge clk);
    chk(fd - fa + 1 == 7, "R4", "fetch cycle of tag 12 behind stall", fd - fa + 1, 7);
    expect_wb(0, 9, 8, fa, "R4");
    expect_wb(1, 10, 12, fa, "R3");
    expect_wb(2, 12, 15, fa, "R5");
    expect_wb(3, 11, 16, fa, "R4");
  endtask

  // R3: fast-unit run retires one per E1 latency
  task automatic t_fast_run();
    int fa, f;
    reset_dut();
    send(13, 1'b0, fa);
    send(14, 1'b0, f);
    send(15, 1'b0, f);
    repeat (16) @(negedge clk);
    expect_wb(0, 13, 6, fa, "R3");
    expect_wb(1, 14, 8, fa, "R3");
    expect_wb(2, 15, 10, fa, "R3");
  endtask

  // R8: tag and select toggling with in_valid low is ignored
  task automatic t_idle_ignored();
    int fa;
    reset_dut();
    for (int i = 0; i < 10; i++) begin
      in_tag = 4'(i);
      in_unit = i[0];
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(n_log == 0, "R8", "retires with in_valid low", n_log, 0);
    send(5, 1'b1, fa);
    repeat (12) @(negedge clk);
    expect_wb(0, 5, 8, fa, "R8");
    chk(n_log == 1, "R8", "single retire after idle", n_log, 1);
  endtask

  initial begin
    t_reset();
    t_mix();
    t_collide();
    t_backpressure();
    t_fast_run();
    t_idle_ignored();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule